// File: doc/BRIEF.md
# DMA Channel Thread Lifecycle Tracker

This block follows the lifecycle of a single DMA channel thread. A start pulse takes a stopped thread into execution. From execution, a thread can finish normally, hit a fault or be killed. Each of these three exits first passes through a draining state. The thread stays in that draining state until every bus load and store it has issued has retired, and only then does it settle.

A normal finish and a kill both settle in the stopped state. A fault settles in a faulted state. The faulted state ignores every ordinary event, and only a kill command issued from the debug side releases it back to stopped.

Outstanding bus transactions are tracked internally. A counter rises on each issue pulse from the bus master and falls on each retire pulse. The lifecycle sequencer reads the counter's empty indication to decide when a draining state may advance. The outputs are the encoded state, a stopped flag and a faulted flag. All pins are plain control and status strobes, because the block moves no data and so has no valid/ready interface.

Top module: `thread_life_tracker`

## Requirements
- R1: After reset, the state code is 0 (stopped), `stopped_o` is 1, `faulted_o` is 0 and the outstanding count is zero.
- R2: In stopped (code 0), a `start_i` pulse moves the thread to executing (code 1) at the next clock edge. Without `start_i`, the events `done_i`, `fault_i`, `kill_i` and `dbg_kill_i` leave the state at 0.
- R3: In executing (code 1), the next state is chosen by a fixed priority:
  - `fault_i` moves the thread to fault-draining (code 4);
  - otherwise `kill_i` or `dbg_kill_i` moves it to killing (code 3);
  - otherwise `done_i` moves it to completing (code 2).
  The higher-priority event wins when several arrive in the same cycle.
- R4: The outstanding count is 5 bits wide. It rises by one on an `issue_i` cycle and falls by one on a `retire_i` cycle, and a cycle with both pulses leaves it unchanged. It can reach 31.
- R5: Completing (code 2) holds while the registered count is nonzero. It moves to stopped (code 0) at the first clock edge at which the count is zero.
- R6: Killing (code 3) holds while the registered count is nonzero. It moves to stopped (code 0) at the first clock edge at which the count is zero.
- R7: Fault-draining (code 4) holds while the registered count is nonzero. It moves to faulted (code 5) at the first clock edge at which the count is zero, and never goes to stopped directly.
- R8: Faulted (code 5) holds under any mix of `start_i`, `done_i`, `fault_i` and `kill_i`.
- R9: In faulted (code 5), a `dbg_kill_i` pulse moves the thread to stopped (code 0) at the next edge.
- R10: A draining state entered with a zero count lasts exactly one cycle before it advances.
- R11: `stopped_o` is 1 exactly when the state is 0. `faulted_o` is 1 exactly when the state is 4 or 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a stopped thread |
| done_i | input | 1 | Execution finished normally |
| fault_i | input | 1 | Fault detected while executing |
| kill_i | input | 1 | Kill requested by the thread |
| dbg_kill_i | input | 1 | Kill command from the debug side |
| issue_i | input | 1 | One bus load or store issued |
| retire_i | input | 1 | One bus load or store retired |
| state_o | output | 3 | Encoded state (0 stopped, 1 executing, 2 completing, 3 killing, 4 fault-draining, 5 faulted) |
| stopped_o | output | 1 | Thread is stopped |
| faulted_o | output | 1 | Thread is on the fault path |

## Verification
The counter assertions rely on two promises from the bus master. First, a retire never arrives when nothing is outstanding. Second, an issue never arrives when the count is already 31. The random stimulus keeps both promises by following the same count in its own model: it withholds retire at zero, withholds issue at the maximum, and issues only while the thread is executing. Lifecycle events are applied at random in every state, including stopped and faulted, so that the ignore and priority rules are exercised. Directed sequences add a full count of 31, simultaneous issue and retire, and drains entered with a zero count.

// File: rtl/thread_life_pkg.sv
package thread_life_pkg;

  typedef enum logic [2:0] {
    TS_STOPPED  = 3'd0,
    TS_EXEC     = 3'd1,
    TS_COMPLETE = 3'd2,
    TS_KILL     = 3'd3,
    TS_FDRAIN   = 3'd4,
    TS_FAULTED  = 3'd5
  } thr_state_e;

endpackage

// File: rtl/thread_txn_counter.sv
module thread_txn_counter #(
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic retire_i,
  output logic empty_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else begin
      unique case ({issue_i, retire_i})
        2'b10:   cnt_q <= cnt_q + CNT_ONE;
        2'b01:   cnt_q <= cnt_q - CNT_ONE;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign empty_o = (cnt_q == CNT_ZERO);

  // R4: the bus master never issues past the top of the count
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !retire_i) |-> (cnt_q != CNT_MAX));

  // R4: the bus master never retires more than it issued
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !issue_i) |-> (cnt_q != CNT_ZERO));

endmodule

// File: rtl/thread_life_seq.sv
module thread_life_seq
  import thread_life_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       fault_i,
  input  logic       kill_i,
  input  logic       dbg_kill_i,
  input  logic       drained_i,
  output thr_state_e state_o
);
  thr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_STOPPED: begin
        if (start_i) state_d = TS_EXEC;
      end
      TS_EXEC: begin
        if (fault_i)                  state_d = TS_FDRAIN;
        else if (kill_i || dbg_kill_i) state_d = TS_KILL;
        else if (done_i)              state_d = TS_COMPLETE;
      end
      TS_COMPLETE, TS_KILL: begin
        if (drained_i) state_d = TS_STOPPED;
      end
      TS_FDRAIN: begin
        if (drained_i) state_d = TS_FAULTED;
      end
      TS_FAULTED: begin
        if (dbg_kill_i) state_d = TS_STOPPED;
      end
      default: state_d = TS_STOPPED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TS_STOPPED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_STOPPED && start_i) |=> (state_q == TS_EXEC));

  a_r3_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_EXEC && fault_i) |=> (state_q == TS_FDRAIN));

  a_r5_complete_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_COMPLETE && !drained_i) |=> (state_q == TS_COMPLETE));

  a_r6_kill_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_KILL && !drained_i) |=> (state_q == TS_KILL));

  a_r7_fdrain_to_faulted: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_FDRAIN && drained_i) |=> (state_q == TS_FAULTED));

  a_r8_faulted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_FAULTED && !dbg_kill_i) |=> (state_q == TS_FAULTED));

  a_r9_dbg_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_FAULTED && dbg_kill_i) |=> (state_q == TS_STOPPED));

endmodule

// File: rtl/thread_life_tracker.sv
module thread_life_tracker
  import thread_life_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       fault_i,
  input  logic       kill_i,
  input  logic       dbg_kill_i,
  input  logic       issue_i,
  input  logic       retire_i,
  output logic [2:0] state_o,
  output logic       stopped_o,
  output logic       faulted_o
);
  logic       drained;
  thr_state_e cur_state;

  thread_txn_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .retire_i (retire_i),
    .empty_o  (drained)
  );

  thread_life_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_i     (done_i),
    .fault_i    (fault_i),
    .kill_i     (kill_i),
    .dbg_kill_i (dbg_kill_i),
    .drained_i  (drained),
    .state_o    (cur_state)
  );

  assign state_o   = cur_state;
  assign stopped_o = (cur_state == TS_STOPPED);
  assign faulted_o = (cur_state == TS_FDRAIN) || (cur_state == TS_FAULTED);

  // R11: the fault flag only rises on the way out of execution
  a_r11_fault_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faulted_o) |-> ($past(cur_state) == TS_EXEC));

endmodule

// File: tb/thread_life_tracker_tb.sv
`timescale 1ns/1ps
module thread_life_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, done_i = 0, fault_i = 0, kill_i = 0, dbg_kill_i = 0;
  logic issue_i = 0, retire_i = 0;
  logic [2:0] state_o;
  logic stopped_o, faulted_o;

  int checks = 0;
  int errors = 0;
  int m_st  = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  thread_life_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_i(done_i),
    .fault_i(fault_i), .kill_i(kill_i), .dbg_kill_i(dbg_kill_i),
    .issue_i(issue_i), .retire_i(retire_i),
    .state_o(state_o), .stopped_o(stopped_o), .faulted_o(faulted_o)
  );

  function automatic int next_st(int st, int cnt, bit st_p, bit dn, bit ft, bit kl, bit dk);
    case (st)
      0: return st_p ? 1 : 0;
      1: if (ft) return 4; else if (kl || dk) return 3; else if (dn) return 2; else return 1;
      2, 3: return (cnt == 0) ? 0 : st;
      4: return (cnt == 0) ? 5 : 4;
      5: return dk ? 0 : 5;
      default: return 0;
    endcase
  endfunction

  function automatic int next_cnt(int cnt, bit is, bit rt);
    if (is && !rt) return cnt + 1;
    if (rt && !is) return cnt - 1;
    return cnt;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    check(tag, int'(state_o), m_st);
    check("R11 stopped flag", int'(stopped_o), (m_st == 0) ? 1 : 0);
    check("R11 faulted flag", int'(faulted_o), (m_st == 4 || m_st == 5) ? 1 : 0);
  endtask

  // called at a negedge: drive, let one posedge pass, compare at the next negedge
  task automatic step(bit st_p, bit dn, bit ft, bit kl, bit dk, bit is, bit rt, string tag);
    int ns, nc;
    start_i = st_p; done_i = dn; fault_i = ft; kill_i = kl; dbg_kill_i = dk;
    issue_i = is; retire_i = rt;
    ns = next_st(m_st, m_cnt, st_p, dn, ft, kl, dk);
    nc = next_cnt(m_cnt, is, rt);
    @(negedge clk);
    m_st = ns; m_cnt = nc;
    check_outputs(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  function automatic string tag_for(int st);
    case (st)
      0: return "R2 stopped";
      1: return "R3 executing";
      2: return "R5 completing";
      3: return "R6 killing";
      4: return "R7 fault-draining";
      default: return "R8 faulted";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    m_st = 0; m_cnt = 0;
    check_outputs("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after release");

    // R2: events other than start are ignored while stopped
    step(0, 1, 1, 1, 1, 0, 0, "R2 ignore events");
    step(1, 0, 0, 0, 0, 0, 0, "R2 start");
    // R3/R7: fault beats kill and done; drain of three
    step(0, 0, 0, 0, 0, 1, 0, "R4 issue");
    step(0, 0, 0, 0, 0, 1, 0, "R4 issue");
    step(0, 0, 0, 0, 0, 1, 0, "R4 issue");
    step(0, 1, 1, 1, 0, 0, 0, "R3 fault priority");
    step(0, 0, 0, 0, 0, 0, 1, "R7 drain wait");
    step(0, 0, 0, 0, 0, 0, 1, "R7 drain wait");
    step(0, 0, 0, 0, 0, 0, 1, "R7 drain wait");
    idle("R7 to faulted");
    // R8: faulted ignores ordinary events; R9 release
    step(1, 1, 1, 1, 0, 0, 0, "R8 faulted hold");
    step(1, 0, 0, 0, 0, 0, 0, "R8 faulted hold start");
    step(0, 0, 0, 0, 1, 0, 0, "R9 dbg kill release");
    // R10: zero-count completing lasts one cycle
    step(1, 0, 0, 0, 0, 0, 0, "R2 start");
    step(0, 1, 0, 0, 0, 0, 0, "R3 done");
    idle("R10 completing zero count");
    // R10/R6: kill with zero count; kill beats done
    step(1, 0, 0, 0, 0, 0, 0, "R2 start");
    step(0, 1, 0, 1, 0, 0, 0, "R3 kill over done");
    idle("R10 killing zero count");
    // R3: debug kill in executing; R4 issue+retire together
    step(1, 0, 0, 0, 0, 0, 0, "R2 start");
    step(0, 0, 0, 0, 0, 1, 1, "R4 issue and retire");
    step(0, 0, 0, 0, 1, 0, 0, "R3 dbg kill in exec");
    idle("R4 count unchanged, R6 kill drains");
    // R4: count to 31 then drain through completing
    step(1, 0, 0, 0, 0, 0, 0, "R2 start");
    for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 0, 1, 0, "R4 fill");
    step(0, 1, 0, 0, 0, 0, 0, "R3 done");
    for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 0, 0, 1, "R5 drain 31");
    idle("R5 completes at zero");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit st_p, dn, ft, kl, dk, is, rt;
      st_p = ($urandom_range(99) < 25);
      dn   = ($urandom_range(99) < 6);
      ft   = ($urandom_range(99) < 4);
      kl   = ($urandom_range(99) < 4);
      dk   = ($urandom_range(99) < ((m_st == 5) ? 15 : 2));
      is   = (m_st == 1) && (m_cnt < 31) && ($urandom_range(99) < 45);
      rt   = (m_cnt > 0) && ($urandom_range(99) < 35);
      step(st_p, dn, ft, kl, dk, is, rt, tag_for(m_st));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule